// File: doc/BRIEF.md
# Turbo-Mode ADC Readout Sequencer

This block runs on the host side of an 18-bit successive-approximation converter that is wired with three pins (convert, serial clock, serial data out) and has its serial data input held high. On each conversion period it raises the convert line, and that edge starts a new conversion. While that conversion runs, the block holds convert high for a programmable first quiet window. It then drops convert and shifts out the result of the previous conversion with a serial clock made from the system clock. After the last serial-clock falling edge, a second programmable quiet window must pass before convert may rise again.

Reading the old sample while the new one converts lets the frame rate stay high even with a slower serial clock. The quiet windows, the serial-clock half period and the conversion period are runtime inputs counted in system-clock cycles. Each assembled word is presented with a one-cycle valid strobe. A conversion period that is too short for one whole frame is stretched: the next convert edge waits until the second quiet window has been met.

Top module: `adc_turbo_rd`

## Requirements
- R1: After reset, `adc_cnv`, `adc_sclk` and `rd_valid` are low and `rd_data` is zero.
- R2: While `conv_en` is high, convert rising edges are spaced max(`conv_period`,1) system-clock cycles apart whenever that spacing is at least the minimum frame length Fmin = Q1 + 36·(`sclk_div`+1) + Q2 + 1, where Q1 = max(`quiet1_cyc`,1) and Q2 = max(`quiet2_cyc`,1).
- R3: Each convert high pulse lasts exactly Q1 system-clock cycles.
- R4: `adc_sclk` stays low while `adc_cnv` is high. After convert falls, the serial clock starts low, and every low phase and every high phase lasts `sclk_div`+1 cycles. A frame has exactly 18 serial-clock periods.
- R5: One data bit is captured on each system-clock edge that drives the serial clock low, so the first capture takes the MSB that was presented when convert fell. Bits are assembled MSB first, so the first bit captured ends in `rd_data[17]`.
- R6: `rd_valid` is a single-cycle pulse. It rises on the same system-clock edge as the 18th serial-clock falling edge of the frame, and `rd_data` carries the new word while it is high.
- R7: Convert rises no sooner than Q2+1 cycles after the last serial-clock falling edge of the previous frame.
- R8: When max(`conv_period`,1) is below Fmin, consecutive convert rising edges are spaced exactly Fmin cycles apart.
- R9: Lowering `conv_en` starts no further conversion. A frame already started still completes and delivers its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Enables periodic conversions |
| conv_period | input | TW (16) | Conversion period in system-clock cycles |
| quiet1_cyc | input | TW (16) | Convert-high time before reading, in cycles |
| quiet2_cyc | input | TW (16) | Time from last serial-clock fall to the next convert rise, in cycles |
| sclk_div | input | DIV_W (8) | Serial-clock half period minus one, in cycles |
| adc_cnv | output | 1 | Convert line to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| rd_data | output | NBITS (18) | Last assembled word |
| rd_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The bench uses three directed settings: every timing input at zero, which gives the densest frame and the smallest divider; a period far longer than a frame; and a period equal to Fmin, which marks the border between R2 and R8. It then runs a series of random settings. A behavioural converter model shifts random words on the serial-clock falls, so a wrong bit order or a capture one edge early or late shows up as a data mismatch. Periods below and above Fmin tell the stretched spacing apart from the programmed spacing. Dropping the enable at random points inside a frame shows whether the frame in flight finishes while no new one begins.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CONV   = 2'd1,
      ST_READ   = 2'd2,
      ST_QUIET2 = 2'd3
   } rd_state_t;

endpackage

// File: rtl/adc_rd_pace.sv
module adc_rd_pace #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [TW-1:0] period,
   output logic          tick
);

   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   logic [TW-1:0] cnt;
   logic [TW-1:0] per_eff;

   initial begin : prm_chk
      if (TW < 2) $fatal(1, "adc_rd_pace: TW must be at least 2");
   end

   assign per_eff = (period == '0) ? ONE : period;
   assign tick    = en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (cnt >= per_eff - ONE) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
   parameter int NBITS = 18,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output logic             fall,
   output logic             last
);

   localparam int NF_W = $clog2(NBITS + 1);
   localparam logic [NF_W-1:0] NF_LAST = NF_W'(NBITS - 1);

   logic [DIV_W-1:0] hc;
   logic [NF_W-1:0]  nfall;
   logic             sclk_q;

   initial begin : prm_chk
      if (NBITS < 2)  $fatal(1, "adc_rd_sclk: NBITS must be at least 2");
      if (DIV_W < 1)  $fatal(1, "adc_rd_sclk: DIV_W must be at least 1");
   end

   assign sclk = sclk_q;
   assign fall = run && (hc == div) && sclk_q;
   assign last = fall && (nfall == NF_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc     <= '0;
         sclk_q <= 1'b0;
         nfall  <= '0;
      end else if (!run) begin
         hc     <= '0;
         sclk_q <= 1'b0;
         nfall  <= '0;
      end else if (hc == div) begin
         hc     <= '0;
         sclk_q <= ~sclk_q;
         if (sclk_q) nfall <= nfall + 1'b1;
      end else begin
         hc <= hc + 1'b1;
      end
   end

   // R4
   fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (nfall <= NF_LAST))
      else $error("serial clock falling-edge count exceeded frame length");

endmodule

// File: rtl/adc_rd_deser.sv
module adc_rd_deser #(
   parameter int NBITS     = 18,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic             last,
   input  logic             sdo,
   output logic [NBITS-1:0] word,
   output logic             vld
);

   logic [NBITS-1:0] sh;
   logic [NBITS-1:0] nxt;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign nxt = {sdo, sh[NBITS-1:1]};
      end else begin : g_msb
         assign nxt = {sh[NBITS-2:0], sdo};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         word <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= last;
         if (cap) sh <= nxt;
         if (last) word <= nxt;
      end
   end

   // R6
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld)
      else $error("valid strobe held longer than one cycle");

endmodule

// File: rtl/adc_turbo_rd.sv
module adc_turbo_rd
   import adc_rd_pkg::*;
#(
   parameter int NBITS     = 18,
   parameter int TW        = 16,
   parameter int DIV_W     = 8,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_en,
   input  logic [TW-1:0]    conv_period,
   input  logic [TW-1:0]    quiet1_cyc,
   input  logic [TW-1:0]    quiet2_cyc,
   input  logic [DIV_W-1:0] sclk_div,
   output logic             adc_cnv,
   output logic             adc_sclk,
   input  logic             adc_sdo,
   output logic [NBITS-1:0] rd_data,
   output logic             rd_valid
);

   localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

   rd_state_t     st;
   logic [TW-1:0] cnt;
   logic [TW-1:0] q1e;
   logic [TW-1:0] q2e;
   logic          tick;
   logic          pend;
   logic          start;
   logic          sck_fall;
   logic          sck_last;

   initial begin : prm_chk
      if (NBITS < 2) $fatal(1, "adc_turbo_rd: NBITS must be at least 2");
      if (TW < 2)    $fatal(1, "adc_turbo_rd: TW must be at least 2");
   end

   assign q1e   = (quiet1_cyc == '0) ? ONE : quiet1_cyc;
   assign q2e   = (quiet2_cyc == '0) ? ONE : quiet2_cyc;
   assign start = (st == ST_IDLE) && conv_en && (pend || tick);

   adc_rd_pace #(.TW(TW)) u_pace (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (conv_en),
      .period (conv_period),
      .tick   (tick)
   );

   adc_rd_sclk #(.NBITS(NBITS), .DIV_W(DIV_W)) u_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_READ),
      .div   (sclk_div),
      .sclk  (adc_sclk),
      .fall  (sck_fall),
      .last  (sck_last)
   );

   adc_rd_deser #(.NBITS(NBITS), .LSB_FIRST(LSB_FIRST)) u_deser (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (sck_fall),
      .last  (sck_last),
      .sdo   (adc_sdo),
      .word  (rd_data),
      .vld   (rd_valid)
   );

   // A period tick that lands while a frame is busy is held here.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend <= 1'b0;
      else if (!conv_en)   pend <= 1'b0;
      else if (start)      pend <= 1'b0;
      else if (tick)       pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         adc_cnv <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st      <= ST_CONV;
                  cnt     <= '0;
                  adc_cnv <= 1'b1;
               end
            end
            ST_CONV: begin
               if (cnt >= q1e - ONE) begin
                  st      <= ST_READ;
                  adc_cnv <= 1'b0;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            ST_READ: begin
               if (sck_last) begin
                  st  <= ST_QUIET2;
                  cnt <= '0;
               end
            end
            default: begin
               if (cnt >= q2e - ONE) st <= ST_IDLE;
               else                  cnt <= cnt + ONE;
            end
         endcase
      end
   end

   // Window counters used only by the checks below.
   logic [TW:0] hi_len;
   logic [TW:0] gap_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len  <= '0;
         gap_len <= '1;
      end else begin
         hi_len <= adc_cnv ? hi_len + 1'b1 : '0;
         if (sck_fall)              gap_len <= '0;
         else if (gap_len != '1)    gap_len <= gap_len + 1'b1;
      end
   end

   // R3
   cnv_quiet1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv) |-> (hi_len >= {1'b0, q1e}))
      else $error("convert dropped before first quiet window");

   // R7
   cnv_quiet2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cnv) |-> (gap_len >= {1'b0, q2e}))
      else $error("convert raised inside second quiet window");

   // R4
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cnv |-> !adc_sclk)
      else $error("serial clock active while convert high");

   // R6
   vld_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (st == ST_QUIET2))
      else $error("valid strobe outside end of read");

endmodule

// File: tb/adc_turbo_rd_tb.sv
`timescale 1ns/1ps
module adc_turbo_rd_tb;

   localparam int NB = 18;
   localparam int TW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_en = 1'b0;
   logic [TW-1:0] conv_period = '0;
   logic [TW-1:0] quiet1_cyc = '0;
   logic [TW-1:0] quiet2_cyc = '0;
   logic [DW-1:0] sclk_div = '0;
   logic          adc_cnv;
   logic          adc_sclk;
   logic          adc_sdo;
   logic [NB-1:0] rd_data;
   logic          rd_valid;

   always #4 clk = ~clk;

   adc_turbo_rd u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_en     (conv_en),
      .conv_period (conv_period),
      .quiet1_cyc  (quiet1_cyc),
      .quiet2_cyc  (quiet2_cyc),
      .sclk_div    (sclk_div),
      .adc_cnv     (adc_cnv),
      .adc_sclk    (adc_sclk),
      .adc_sdo     (adc_sdo),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int max1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   function automatic int fmin(input int q1, input int q2, input int d);
      return max1(q1) + 2 * NB * (d + 1) + max1(q2) + 1;
   endfunction

   // Behavioural converter: MSB at convert fall, next bit after each clock fall.
   logic [NB-1:0] cur = '0;
   int            idx = 0;
   logic [NB-1:0] exp_q[$];

   initial adc_sdo = 1'b0;

   always @(negedge adc_cnv) begin
      if (rst_n) begin
         cur = NB'($urandom());
         exp_q.push_back(cur);
         idx = 0;
         adc_sdo = cur[NB-1];
      end
   end

   always @(negedge adc_sclk) begin
      if (rst_n && !adc_cnv) begin
         idx++;
         adc_sdo = (idx < NB) ? cur[NB-1-idx] : 1'b0;
      end
   end

   // Monitor, sampled on the falling system-clock edge.
   int cyc = 0;
   always @(posedge clk) cyc++;

   int  cfg_q1, cfg_q2, cfg_d, cfg_p;
   bit  have_rise = 1'b0;
   bit  have_fall = 1'b0;
   int  last_rise = 0;
   int  last_fall = 0;
   int  last_tog = 0;
   int  nfalls = 0;
   int  rises = 0;
   int  vlds = 0;
   int  sclk_bad = 0;
   bit  prev_cnv = 1'b0;
   bit  prev_sclk = 1'b0;
   bit  prev_vld = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (adc_cnv && !prev_cnv) begin
            if (have_rise) begin
               int fm;
               int pe;
               fm = fmin(cfg_q1, cfg_q2, cfg_d);
               pe = max1(cfg_p);
               if (pe >= fm) chk(cyc - last_rise == pe, "R2 spacing", cyc - last_rise, pe);
               else          chk(cyc - last_rise == fm, "R8 stretched spacing", cyc - last_rise, fm);
            end
            if (have_fall)
               chk(cyc - last_fall >= max1(cfg_q2) + 1, "R7 quiet2 gap", cyc - last_fall, max1(cfg_q2) + 1);
            have_rise = 1'b1;
            last_rise = cyc;
            rises++;
            sclk_bad = 0;
         end
         if (adc_cnv && adc_sclk) sclk_bad++;
         if (!adc_cnv && prev_cnv) begin
            chk(cyc - last_rise == max1(cfg_q1), "R3 convert high time", cyc - last_rise, max1(cfg_q1));
            chk(sclk_bad == 0, "R4 sclk low during convert", sclk_bad, 0);
            nfalls = 0;
            last_tog = cyc;
         end
         if (adc_sclk != prev_sclk) begin
            chk(cyc - last_tog == cfg_d + 1, "R4 half period", cyc - last_tog, cfg_d + 1);
            last_tog = cyc;
            if (!adc_sclk) begin
               nfalls++;
               last_fall = cyc;
               have_fall = 1'b1;
            end
         end
         if (rd_valid) begin
            logic [NB-1:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            chk(nfalls == NB, "R4 18 clock periods", nfalls, NB);
            chk(last_fall == cyc, "R6 valid with 18th fall", last_fall, cyc);
            chk(rd_data == e, "R5 word MSB first", rd_data, e);
            vlds++;
         end
         if (prev_vld) chk(!rd_valid, "R6 single-cycle valid", rd_valid, 0);
      end
      prev_cnv  = adc_cnv;
      prev_sclk = adc_sclk;
      prev_vld  = rd_valid;
   end

   task automatic configure(input int q1, input int q2, input int d, input int p);
      @(posedge clk); #1;
      cfg_q1 = q1; cfg_q2 = q2; cfg_d = d; cfg_p = p;
      quiet1_cyc  = TW'(q1);
      quiet2_cyc  = TW'(q2);
      sclk_div    = DW'(d);
      conv_period = TW'(p);
      have_rise   = 1'b0;
   endtask

   // Run n frames, drop enable after a delay, then confirm R9.
   task automatic run_frames(input int n, input int drop_dly);
      int v0;
      int r0;
      int fm;
      v0 = vlds;
      fm = fmin(cfg_q1, cfg_q2, cfg_d);
      @(posedge clk); #1;
      conv_en = 1'b1;
      while (vlds < v0 + n) @(posedge clk);
      repeat (drop_dly) @(posedge clk);
      #1;
      conv_en = 1'b0;
      @(negedge clk);
      r0 = rises;
      repeat (2 * fm + 20) @(posedge clk);
      @(negedge clk);
      chk(rises == r0, "R9 no start after disable", rises - r0, 0);
      chk(exp_q.size() == 0, "R9 frame in flight delivered", exp_q.size(), 0);
   endtask

   initial begin : main
      void'($urandom(32'd4021));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(adc_cnv == 1'b0, "R1 cnv reset", adc_cnv, 0);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(adc_cnv == 1'b0, "R1 cnv after reset", adc_cnv, 0);
      chk(adc_sclk == 1'b0, "R1 sclk after reset", adc_sclk, 0);
      chk(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);
      chk(rd_data == '0, "R1 data after reset", rd_data, 0);

      // Directed corners: all zero, long period, period equal to Fmin.
      configure(0, 0, 0, 0);
      run_frames(5, 0);
      configure(5, 3, 1, 200);
      run_frames(3, 7);
      configure(4, 2, 0, fmin(4, 2, 0));
      run_frames(4, 1);
      configure(2, 6, 2, fmin(2, 6, 2) - 1);
      run_frames(3, 3);

      for (int k = 0; k < 10; k++) begin
         int q1;
         int q2;
         int d;
         int p;
         int dly;
         q1  = int'($urandom_range(0, 20));
         q2  = int'($urandom_range(0, 20));
         d   = int'($urandom_range(0, 3));
         p   = int'($urandom_range(0, 250));
         dly = int'($urandom_range(0, fmin(q1, q2, d)));
         configure(q1, q2, d, p);
         run_frames(int'($urandom_range(2, 5)), dly);
      end

      chk(vlds > 0, "R5 words received", vlds, 1);
      done = 1'b1;
   end

   initial begin : watchdog
      int n;
      n = 0;
      while (!done && n < 150000) begin
         @(posedge clk);
         n++;
      end
      if (!done) chk(1'b0, "watchdog expired", n, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule